// File: doc/BRIEF.md
# Partitioned SIMD Bit-Field Slicer

This block takes a 64-bit packed SIMD word and a lane-mode code, splits the word into elements of 8, 16, 32 or 64 bits as the mode selects, and pulls the same three-bit field (bit 3 up to bit 5 of each element) out of every element. Every result is exactly three bits wide in every mode. Each result is placed in a fixed three-bit slot, and there are eight slots in total.

The slot position follows the lowest 8-bit lane of the element it came from. Wider elements therefore leave unused slots between the results. Those slots are forced to zero. An eight-bit valid mask marks the slots that hold real results. The block is purely combinational. Downstream partitioned arithmetic can use the mask to tell real results from padding. The field start and length are elaboration-time parameters.

Top module: `simd_field_slicer`

## Requirements
- R1: Mode code 0 (8-bit elements): slot j (output bits 3j+2..3j) equals input bits 8j+5..8j+3 for j = 0..7, and the valid mask is 8'hFF.
- R2: Mode code 1 (16-bit elements): slot 2k equals bits 16k+5..16k+3 for k = 0..3, the odd slots are zero, and the valid mask is 8'h55.
- R3: Mode code 2 (32-bit elements): slot 0 equals bits 5..3, slot 4 equals bits 37..35, all other slots are zero, and the valid mask is 8'h11.
- R4: Mode code 3 (64-bit element): slot 0 equals bits 5..3, all other slots are zero, and the valid mask is 8'h01.
- R5: Every slot whose valid bit is clear drives zero, and every valid slot sits at the slot index of its element's lowest 8-bit lane.
- R6: Mode codes 4 through 7 are illegal: the valid mask is 8'h00 and the whole slot output is zero.
- R7: Each result is three bits wide in every mode. Input bits outside the selected field of each element have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | 64 | Packed SIMD source word, lane 0 in bits 7..0 |
| mode_i | input | 3 | Element width code: 0=8, 1=16, 2=32, 3=64 bits; 4..7 illegal |
| slots_o | output | 24 | Eight three-bit result slots, slot j in bits 3j+2..3j |
| valid_o | output | 8 | One bit per slot, set when the slot holds a real result |

## Verification
The bench targets the padding slots in the wide modes. A design that forwards lane data there instead of zero shows stray bits in odd slots when the input is all ones. Wrong slot placement is caught with walking-one inputs, because a design that packs results contiguously or indexes the element from the wrong base puts a set bit in the wrong slot. The illegal mode codes are driven with busy inputs to expose a design that decodes only the low mode bits and so produces a non-zero mask or leaks data. Inputs that set only bits outside the field show whether the extraction window is shifted or too wide.

// File: rtl/simd_field_slicer_pkg.sv
package simd_field_slicer_pkg;

    localparam int unsigned LANE_W    = 8;
    localparam int unsigned NUM_LANES = 8;
    localparam int unsigned MODE_W    = 3;

    typedef enum logic [MODE_W-1:0] {
        EW_8  = 3'd0,
        EW_16 = 3'd1,
        EW_32 = 3'd2,
        EW_64 = 3'd3
    } elem_mode_e;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m, input int unsigned n_modes);
        return 32'(m) < n_modes;
    endfunction

endpackage

// File: rtl/simd_slot_mask.sv
module simd_slot_mask #(
    parameter int unsigned NUM_LANES = 8,
    parameter int unsigned MODE_W    = 3
) (
    input  logic [MODE_W-1:0]    mode_i,
    output logic [NUM_LANES-1:0] mask_o
);
    localparam int unsigned N_MODES = $clog2(NUM_LANES) + 1;

    typedef struct packed {
        logic [NUM_LANES-1:0] mask;
    } mask_st_t;

    mask_st_t m_d;

    always_comb begin
        m_d = '0;
        if (simd_field_slicer_pkg::mode_legal(mode_i, N_MODES)) begin
            for (int j = 0; j < NUM_LANES; j++) begin
                // a slot is live when it is the lowest lane of its element
                m_d.mask[j] = ((j & ((1 << mode_i) - 1)) == 0);
            end
        end
    end

    assign mask_o = m_d.mask;

    // slot 0 always starts an element in a legal mode
    always_comb begin
        if (simd_field_slicer_pkg::mode_legal(mode_i, N_MODES)) begin
            p_slot0_live_r4: assert (mask_o[0])
                else $error("slot 0 not live in legal mode");
            p_live_count_r3: assert ($countones(mask_o) == (NUM_LANES >> mode_i))
                else $error("live slot count mismatch");
        end else begin
            p_illegal_empty_r6: assert (mask_o == '0)
                else $error("illegal mode produced live slots");
        end
    end

endmodule

// File: rtl/simd_slot_extract.sv
module simd_slot_extract #(
    parameter int unsigned LANE_W    = 8,
    parameter int unsigned SLICE_LO  = 3,
    parameter int unsigned SLICE_LEN = 3
) (
    input  logic [LANE_W-1:0]    lane_i,
    input  logic                 live_i,
    output logic [SLICE_LEN-1:0] field_o
);
    typedef struct packed {
        logic [SLICE_LEN-1:0] field;
    } ext_st_t;

    ext_st_t e_d;

    always_comb begin
        e_d = '0;
        if (live_i) begin
            e_d.field = lane_i[SLICE_LO +: SLICE_LEN];
        end
    end

    assign field_o = e_d.field;

    always_comb begin
        if (!live_i) begin
            p_pad_zero_r5: assert (field_o == '0)
                else $error("padding slot not zero");
        end
    end

endmodule

// File: rtl/simd_field_slicer.sv
module simd_field_slicer #(
    parameter int unsigned LANE_W    = simd_field_slicer_pkg::LANE_W,
    parameter int unsigned NUM_LANES = simd_field_slicer_pkg::NUM_LANES,
    parameter int unsigned MODE_W    = simd_field_slicer_pkg::MODE_W,
    parameter int unsigned SLICE_LO  = 3,
    parameter int unsigned SLICE_LEN = 3
) (
    input  logic [LANE_W*NUM_LANES-1:0]    vec_i,
    input  logic [MODE_W-1:0]              mode_i,
    output logic [SLICE_LEN*NUM_LANES-1:0] slots_o,
    output logic [NUM_LANES-1:0]           valid_o
);
    localparam int unsigned VEC_W = LANE_W * NUM_LANES;
    localparam int unsigned OUT_W = SLICE_LEN * NUM_LANES;

    generate
        if (SLICE_LO + SLICE_LEN > LANE_W) begin : g_bad_field
            $error("field must lie inside one lane");
        end
    endgenerate

    typedef struct packed {
        logic [OUT_W-1:0]     slots;
        logic [NUM_LANES-1:0] valid;
    } top_st_t;

    logic [NUM_LANES-1:0] mask_w;
    logic [OUT_W-1:0]     field_w;
    top_st_t              t_d;

    simd_slot_mask #(
        .NUM_LANES (NUM_LANES),
        .MODE_W    (MODE_W)
    ) u_mask (
        .mode_i (mode_i),
        .mask_o (mask_w)
    );

    // the first lane of element k sits at lane index k*(W/LANE_W),
    // so slot j always draws from lane j when it is live
    for (genvar j = 0; j < NUM_LANES; j++) begin : g_slot
        simd_slot_extract #(
            .LANE_W    (LANE_W),
            .SLICE_LO  (SLICE_LO),
            .SLICE_LEN (SLICE_LEN)
        ) u_ext (
            .lane_i  (vec_i[j*LANE_W +: LANE_W]),
            .live_i  (mask_w[j]),
            .field_o (field_w[j*SLICE_LEN +: SLICE_LEN])
        );
    end

    always_comb begin
        t_d       = '0;
        t_d.valid = mask_w;
        t_d.slots = field_w;
    end

    assign slots_o = t_d.slots;
    assign valid_o = t_d.valid;

    always_comb begin
        p_slot0_src_r1: assert (!valid_o[0] || slots_o[SLICE_LEN-1:0] == vec_i[SLICE_LO +: SLICE_LEN])
            else $error("slot 0 data mismatch");
        if (valid_o == '0) begin
            p_empty_out_r6: assert (slots_o == '0)
                else $error("output not zero with empty mask");
        end
        if (valid_o == 8'h55) begin
            p_odd_pad_r2: assert ((slots_o & {NUM_LANES/2{{SLICE_LEN{1'b1}}, {SLICE_LEN{1'b0}}}}) == '0)
                else $error("odd slot not zero in 16-bit mode");
        end
    end

    logic unused_w;
    assign unused_w = ^VEC_W;

endmodule

// File: tb/tb_simd_field_slicer.sv
module tb_simd_field_slicer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic [63:0] vec;
    logic [2:0]  mode;
    logic [23:0] slots;
    logic [7:0]  valid;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_field_slicer dut (
        .vec_i   (vec),
        .mode_i  (mode),
        .slots_o (slots),
        .valid_o (valid)
    );

    function automatic logic [23:0] ref_slots(input logic [63:0] v, input logic [2:0] m);
        logic [23:0] r = '0;
        if (m < 4) begin
            int w  = 8 << m;
            int n  = 8 >> m;
            for (int k = 0; k < n; k++) begin
                logic [63:0] e = (v >> (k*w));
                if (w < 64) e = e & ((64'd1 << w) - 1);
                r[(k*(w/8))*3 +: 3] = e[5:3];
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_valid(input logic [2:0] m);
        case (m)
            3'd0: return 8'hFF;
            3'd1: return 8'h55;
            3'd2: return 8'h11;
            3'd3: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic apply(input logic [63:0] v, input logic [2:0] m, input string req);
        vec  = v;
        mode = m;
        @(negedge clk);
        total++;
        if (slots !== ref_slots(v, m) || valid !== ref_valid(m)) begin
            bad++;
            $display("FAIL %s mode=%0d vec=%h slots act=%h exp=%h valid act=%h exp=%h",
                     req, m, v, slots, ref_slots(v, m), valid, ref_valid(m));
        end
    endtask

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            default: return "R6";
        endcase
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        vec  = '0;
        mode = '0;
        @(negedge clk);
        // reset-like idle state: zero input gives zero slots, full mask
        apply(64'h0, 3'd0, "R1");
        // padding with all ones, per mode (R5)
        for (int m = 0; m < 4; m++) apply(64'hFFFF_FFFF_FFFF_FFFF, 3'(m), "R5");
        // walking ones across the whole word in every legal mode (R5 placement)
        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 64; b++) apply(64'd1 << b, 3'(m), req_of(3'(m)));
        // bits outside the field only: output must be zero (R7)
        for (int m = 0; m < 4; m++) apply(64'hC7C7_C7C7_C7C7_C7C7, 3'(m), "R7");
        // field bits only
        apply(64'h3838_3838_3838_3838, 3'd0, "R1");
        apply(64'h0000_0028_0000_0010, 3'd2, "R3");
        apply(64'h0018_0020_0008_0038, 3'd1, "R2");
        apply(64'hFFFF_FFFF_FFFF_FF28, 3'd3, "R4");
        // illegal codes with busy data (R6)
        for (int m = 4; m < 8; m++) apply(64'hFFFF_FFFF_FFFF_FFFF, 3'(m), "R6");
        // random
        for (int i = 0; i < 2000; i++) begin
            logic [63:0] v = {$urandom, $urandom};
            logic [2:0]  m = 3'($urandom % 8);
            apply(v, m, req_of(m));
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule